// File: doc/BRIEF.md
# Pre-Add Multiply-ALU Arithmetic Slice

This block is a pipelined arithmetic slice built in plain RTL. Its internal layout follows a hard multiply-accumulate block: an optional pre-adder combines two operands, an optional multiplier scales the result by a third operand, and an ALU stage adds, subtracts or passes a fourth operand. Static configuration inputs choose which stages take part. With five configuration bits there are 32 datapath shapes, including plain multiply, multiply-add, a 3-input adder and a simple register pass.

No intermediate result is brought out. To read the value of an earlier stage, every later stage must be bypassed so that the value flows through to the wide output `p_out`. The pipeline depth depends on the configuration. When the pre-adder is in use there are four register stages. Otherwise there are three, because the pre-adder register is skipped. A valid bit travels through a matching delay line, so `out_valid` marks exactly the cycles that carry a result. The configuration is intended to be static. Change it only while no valid data is in flight.

Top module: `preadd_mul_alu_slice`

## Requirements
- R1: While reset is asserted, and until the first result is due afterwards, `out_valid` is 0. Reset clears `p_out` to 0.
- R2: A sample accepted with `in_valid`=1 shows its result with `out_valid`=1 exactly 4 clock edges later when `cfg_pre_en`=1, and exactly 3 edges later when `cfg_pre_en`=0. `out_valid` is never 1 in any other cycle.
- R3: When `cfg_pre_en`=1, the first operand X is D+A if `cfg_pre_sub`=0 and D−A if `cfg_pre_sub`=1. When `cfg_pre_en`=0, X is A and `cfg_pre_sub` has no effect.
- R4: When `cfg_mul_en`=1, the intermediate M is X×B. When `cfg_mul_en`=0, M is X sign-extended and B has no effect.
- R5: `cfg_alu_op` selects the output: 0 gives M, 1 gives M+C, 2 gives M−C, 3 gives C−M. With code 0, C has no effect.
- R6: With `cfg_pre_en`=1, `cfg_pre_sub`=0, `cfg_mul_en`=0 and `cfg_alu_op`=1, the slice acts as a 3-input adder and outputs D+A+C four edges after the input.
- R7: All operands are two's complement. The result is reduced modulo 2^PW, so extreme operands wrap and do not saturate.
- R8: The slice accepts a new sample on every cycle. Back-to-back inputs give back-to-back results in the same order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_pre_en | input | 1 | Enable the pre-adder (adds one stage of latency) |
| cfg_pre_sub | input | 1 | Pre-adder computes D−A instead of D+A |
| cfg_mul_en | input | 1 | Enable the multiplier by B |
| cfg_alu_op | input | 2 | ALU code: 0 pass M, 1 M+C, 2 M−C, 3 C−M |
| in_valid | input | 1 | Operands on this cycle are a sample |
| a_in | input | AW | Signed operand A |
| d_in | input | AW | Signed operand D |
| b_in | input | BW | Signed multiplier operand B |
| c_in | input | CW | Signed ALU operand C |
| out_valid | output | 1 | `p_out` carries a result |
| p_out | output | PW | Signed result |

## Verification
A result is due four clock edges after its input when the pre-adder is enabled, and three edges after its input in every other shape. The bench tags each sample it drives with a due cycle, computed from its own configuration at drive time. At every falling edge it compares the head of the queue of expected results with the outputs. A result that arrives early or late, or an `out_valid` that arrives with nothing due, fails as R2. Because samples are checked against their due cycles, a mismatch shows up in the cycle in which it occurs. Checks cover all 32 configurations, each with a continuous run of inputs followed by inputs with gaps.

// File: rtl/preadd_mul_alu_slice.sv
module preadd_mul_alu_slice #(
  parameter int AW = 25,
  parameter int BW = 18,
  parameter int CW = 48,
  parameter int PW = 48
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_pre_en,
  input  logic                 cfg_pre_sub,
  input  logic                 cfg_mul_en,
  input  logic [1:0]           cfg_alu_op,
  input  logic                 in_valid,
  input  logic signed [AW-1:0] a_in,
  input  logic signed [AW-1:0] d_in,
  input  logic signed [BW-1:0] b_in,
  input  logic signed [CW-1:0] c_in,
  output logic                 out_valid,
  output logic signed [PW-1:0] p_out
);

  localparam int XW = AW + 1;
  localparam int MW = XW + BW;

  // stage 1: operand registers
  logic signed [AW-1:0] a1, d1;
  logic signed [BW-1:0] b1;
  logic signed [CW-1:0] c1;
  logic                 v1;

  // stage 2: pre-adder register (used only when cfg_pre_en)
  logic signed [XW-1:0] x2;
  logic signed [BW-1:0] b2;
  logic signed [CW-1:0] c2;
  logic                 v2;

  // stage 3: multiplier register
  logic signed [PW-1:0] m3, c3;
  logic                 v3;

  logic signed [XW-1:0] pre_sum, x_sel;
  logic signed [BW-1:0] b_sel;
  logic signed [CW-1:0] c_sel;
  logic                 v_sel;
  logic signed [MW-1:0] prod;
  logic signed [PW-1:0] m_next, alu_next;

  assign pre_sum = cfg_pre_sub ? (XW'(d1) - XW'(a1)) : (XW'(d1) + XW'(a1));

  assign x_sel = cfg_pre_en ? x2 : XW'(a1);
  assign b_sel = cfg_pre_en ? b2 : b1;
  assign c_sel = cfg_pre_en ? c2 : c1;
  assign v_sel = cfg_pre_en ? v2 : v1;

  assign prod   = MW'(x_sel) * MW'(b_sel);
  assign m_next = cfg_mul_en ? PW'(prod) : PW'(x_sel);

  always_comb begin
    case (cfg_alu_op)
      2'd0:    alu_next = m3;
      2'd1:    alu_next = m3 + c3;
      2'd2:    alu_next = m3 - c3;
      default: alu_next = c3 - m3;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a1 <= '0; d1 <= '0; b1 <= '0; c1 <= '0; v1 <= 1'b0;
      x2 <= '0; b2 <= '0; c2 <= '0; v2 <= 1'b0;
      m3 <= '0; c3 <= '0; v3 <= 1'b0;
      p_out <= '0; out_valid <= 1'b0;
    end else begin
      a1 <= a_in; d1 <= d_in; b1 <= b_in; c1 <= c_in; v1 <= in_valid;
      x2 <= pre_sum; b2 <= b1; c2 <= c1; v2 <= v1;
      m3 <= m_next; c3 <= PW'(c_sel); v3 <= v_sel;
      p_out <= alu_next; out_valid <= v3;
    end
  end

  // edges seen since reset, saturating; keeps $past windows inside reset history
  logic [2:0] edges;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) edges <= '0;
    else if (edges != 3'd7) edges <= edges + 3'd1;
  end

  AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (edges < 3'd2) |-> !out_valid); // R1

  AST_LATENCY_PRE: assert property (@(posedge clk) disable iff (!rst_n)
    (edges >= 3'd4 && cfg_pre_en) |-> (out_valid == $past(in_valid, 4))); // R2

  AST_LATENCY_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    (edges >= 3'd3 && !cfg_pre_en) |-> (out_valid == $past(in_valid, 3))); // R2

  AST_PASS_THROUGH_A: assert property (@(posedge clk) disable iff (!rst_n)
    (edges >= 3'd3 && out_valid && !cfg_pre_en && !cfg_mul_en && cfg_alu_op == 2'd0)
      |-> (p_out == PW'($signed($past(a_in, 3))))); // R4

endmodule

// File: tb/preadd_mul_alu_slice_tb_top.sv
module preadd_mul_alu_slice_tb_top;
  localparam int AW = 25, BW = 18, CW = 48, PW = 48;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_pre_en = 1'b0, cfg_pre_sub = 1'b0, cfg_mul_en = 1'b0;
  logic [1:0] cfg_alu_op = 2'd0;
  logic in_valid = 1'b0;
  logic signed [AW-1:0] a_in = '0, d_in = '0;
  logic signed [BW-1:0] b_in = '0;
  logic signed [CW-1:0] c_in = '0;
  logic out_valid;
  logic signed [PW-1:0] p_out;

  always #5 clk = ~clk;

  preadd_mul_alu_slice #(.AW(AW), .BW(BW), .CW(CW), .PW(PW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_pre_en(cfg_pre_en), .cfg_pre_sub(cfg_pre_sub),
    .cfg_mul_en(cfg_mul_en), .cfg_alu_op(cfg_alu_op), .in_valid(in_valid),
    .a_in(a_in), .d_in(d_in), .b_in(b_in), .c_in(c_in),
    .out_valid(out_valid), .p_out(p_out));

  int checks = 0, errors = 0, tick = 0;
  bit done = 0;
  logic [PW-1:0] q_val[$];
  int q_due[$];
  string q_tag[$];

  function automatic logic [PW-1:0] model(input logic pe, input logic ps, input logic me,
      input logic [1:0] op, input logic [AW-1:0] a, input logic [AW-1:0] d,
      input logic [BW-1:0] b, input logic [CW-1:0] c);
    longint sa, sd, sb, sc, x, m, r;
    sa = longint'($signed(a)); sd = longint'($signed(d));
    sb = longint'($signed(b)); sc = longint'($signed(c));
    x = pe ? (ps ? sd - sa : sd + sa) : sa;
    m = me ? x * sb : x;
    case (op)
      2'd0: r = m;
      2'd1: r = m + sc;
      2'd2: r = m - sc;
      default: r = sc - m;
    endcase
    return r[PW-1:0];
  endfunction

  task automatic check(input bit ok, input string tag, input logic [PW-1:0] act,
                       input logic [PW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (tick %0d)", tag, act, exp, tick);
    end
  endtask

  task automatic check_out();
    if (q_due.size() != 0 && q_due[0] == tick) begin
      check(out_valid == 1'b1, "R2", PW'(out_valid), PW'(1));
      check(p_out == q_val[0], q_tag[0], p_out, q_val[0]);
      void'(q_due.pop_front()); void'(q_val.pop_front()); void'(q_tag.pop_front());
    end else if (out_valid) begin
      check(1'b0, "R2", PW'(out_valid), PW'(0));
    end
  endtask

  task automatic step(input logic vld, input logic [AW-1:0] a, input logic [AW-1:0] d,
                      input logic [BW-1:0] b, input logic [CW-1:0] c, input string tag);
    @(negedge clk);
    tick++;
    check_out();
    in_valid = vld; a_in = a; d_in = d; b_in = b; c_in = c;
    if (vld) begin
      q_val.push_back(model(cfg_pre_en, cfg_pre_sub, cfg_mul_en, cfg_alu_op, a, d, b, c));
      q_due.push_back(tick + (cfg_pre_en ? 4 : 3));
      q_tag.push_back(tag);
    end
  endtask

  function automatic string cfg_tag();
    if (cfg_pre_en && !cfg_pre_sub && !cfg_mul_en && cfg_alu_op == 2'd1) return "R6";
    if (cfg_alu_op != 2'd0) return "R5";
    if (cfg_mul_en) return "R4";
    return "R3";
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(out_valid == 1'b0, "R1", PW'(out_valid), PW'(0));
    check(p_out == '0, "R1", p_out, '0);
    rst_n = 1'b1;
    for (int cf = 0; cf < 32; cf++) begin
      @(negedge clk);
      {cfg_pre_en, cfg_pre_sub, cfg_mul_en, cfg_alu_op} = 5'(cf);
      // R7: extreme operands that wrap
      step(1'b1, {1'b0, {(AW-1){1'b1}}}, {1'b0, {(AW-1){1'b1}}}, {1'b0, {(BW-1){1'b1}}},
           {1'b0, {(CW-1){1'b1}}}, "R7");
      step(1'b1, {1'b1, {(AW-1){1'b0}}}, {1'b1, {(AW-1){1'b0}}}, {1'b1, {(BW-1){1'b0}}},
           {1'b1, {(CW-1){1'b0}}}, "R7");
      // R8: continuous run
      for (int k = 0; k < 10; k++)
        step(1'b1, AW'($urandom), AW'($urandom), BW'($urandom),
             {16'($urandom), 32'($urandom)}, "R8");
      // gapped run, checked per configuration
      for (int k = 0; k < 12; k++)
        step(1'($urandom), AW'($urandom), AW'($urandom), BW'($urandom),
             {16'($urandom), 32'($urandom)}, cfg_tag());
      for (int k = 0; k < 6; k++) step(1'b0, '0, '0, '0, '0, "R2");
      check(q_due.size() == 0, "R2", PW'(q_due.size()), PW'(0));
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule